// File: doc/BRIEF.md
# Two-Wire Block-Transfer Control Register Slave

This block is a slave-only two-wire serial port that holds six 8-bit control registers. A bus master updates them with block writes and reads them back with block reads. Neither direction supports sub-addressing. A write always starts at register 0 and continues in order. A read always returns a byte count followed by the registers in order. The bus clock and data lines arrive as plain inputs. They are oversampled by a system clock at least ten times the bit rate. The slave answers on the data line through a pull-down enable that drives an external open-drain pad.

In a write, the address byte is followed by two bytes that the slave acknowledges and then discards: a command code and a byte count. Every byte after those lands in the next register. Bytes beyond the sixth register are acknowledged and dropped. In a read, the slave shifts out the count and then the registers, most significant bit first. It samples the master's acknowledge after each byte. A power-down input silences the port and keeps the stored values. The register contents are also presented in parallel for the rest of the chip to use.

Top module: `ctlbus_slave`

## Requirements
- R1: After reset the registers hold reg0=0xF6, reg1=0x3F, reg2=0xE0, reg3=0x7E, reg4=0x00, reg5=0x00, and the data pull-down is off. On `regs_flat`, register k sits at bits [8k+7:8k].
- R2: A start is data falling while the clock is high. A stop is data rising while the clock is high. A stop or a repeated start at any bit position abandons the byte in progress without writing it, and a repeated start begins a new transfer at once.
- R3: The address byte 0xD2 selects a write and 0xD3 selects a read, and both are acknowledged. An acknowledge is the data line held low while the clock is high on the ninth bit. Any other address byte gets no acknowledge, and every later byte up to the next start is ignored.
- R4: In a write, the two bytes after the address are acknowledged and do not change any register. The bytes after them load reg0, reg1 and onward in order. Each register takes its new value at the acknowledge of its byte.
- R5: Write bytes after the sixth data byte are still acknowledged but change no register.
- R6: A read returns the value 6 first, then reg0 through reg5, each most significant bit first.
- R7: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing more until the next start.
- R8: While power-down is high, the slave never pulls the data line, ignores all bus traffic and keeps every register unchanged. It answers normally again once power-down falls.
- R9: The slave pulls the data line only during an acknowledge bit or a read data bit. While a master shifts a byte in, the slave never pulls the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | High: bus port disabled, registers retained |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | High: pull the data line low |
| regs_flat | output | 48 | All six registers, register k at bits [8k+7:8k] |

## Verification
The assertions assume that the master changes the data line only while the clock is low, except when it makes a start or a stop. They also assume that each clock level lasts many system clocks, so that every synchronized edge is seen before the line moves again. The bench drives the bus with a quarter-bit phase of 25 system clocks. It changes data only in the low phase, a full quarter after each falling edge. It puts the data line together as the master's drive ANDed with the inverse of the slave's pull. This lets the slave's pull-down win exactly as an open-drain pad would.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RX      = 3'd1,
        ST_ACKWAIT = 3'd2,
        ST_ACK     = 3'd3,
        ST_TX      = 3'd4,
        ST_MACK    = 3'd5
    } eng_st_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

endpackage

// File: rtl/ctlbus_sync.sv
module ctlbus_sync
    import ctlbus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.scl_sh = {sy_q.scl_sh[STAGES-2:0], scl_in};
        sy_d.sda_sh = {sy_q.sda_sh[STAGES-2:0], sda_in};
        sy_d.scl_p  = sy_q.scl_sh[STAGES-1];
        sy_d.sda_p  = sy_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    logic scl_s, sda_s;
    assign scl_s = sy_q.scl_sh[STAGES-1];
    assign sda_s = sy_q.sda_sh[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~sy_q.scl_p;
        ev.scl_fall = ~scl_s & sy_q.scl_p;
        ev.start    = scl_s & sy_q.scl_p & sy_q.sda_p & ~sda_s;
        ev.stop     = scl_s & sy_q.scl_p & ~sy_q.sda_p & sda_s;
    end

endmodule

// File: rtl/ctlbus_regfile.sv
module ctlbus_regfile #(
    parameter int                  DW        = 8,
    parameter int                  NREG      = 6,
    parameter logic [NREG*DW-1:0]  RESET_VAL = '0,
    localparam int                 RIDX_W    = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RIDX_W-1:0]    wr_idx,
    input  logic [DW-1:0]        wr_data,
    output logic [NREG*DW-1:0]   regs_flat
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && (wr_idx == RIDX_W'(g))) begin
                r_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= RESET_VAL[g*DW +: DW];
            end else begin
                r_q <= r_d;
            end
        end

        assign regs_flat[g*DW +: DW] = r_q;
    end

endmodule

// File: rtl/ctlbus_engine.sv
module ctlbus_engine
    import ctlbus_pkg::*;
#(
    parameter int          DW     = 8,
    parameter int          NREG   = 6,
    parameter logic [6:0]  ADDR7  = 7'h69,
    parameter int          IDX_W  = 4,
    localparam int         RIDX_W = $clog2(NREG),
    localparam int         BC_W   = $clog2(DW + 1),
    localparam int         WR_HDR = 3,
    localparam int         RD_HDR = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_down,
    input  bus_ev_t              ev,
    input  logic [NREG*DW-1:0]   regs_flat,
    output logic                 wr_en,
    output logic [RIDX_W-1:0]    wr_idx,
    output logic [DW-1:0]        wr_data,
    output logic                 sda_pull
);

    typedef struct packed {
        eng_st_e          st;
        logic [BC_W-1:0]  bitcnt;
        logic [DW-1:0]    sh;
        logic [IDX_W-1:0] idx;
        logic             rd;
        logic             ack;
        logic             mack;
        logic             pull;
    } eng_t;

    localparam eng_t ENG_IDLE = '{st: ST_IDLE, bitcnt: '0, sh: '0, idx: '0,
                                  rd: 1'b0, ack: 1'b0, mack: 1'b0, pull: 1'b0};

    eng_t eng_d, eng_q;

    logic [IDX_W-1:0] idx_nx;
    logic [DW-1:0]    tx_byte;
    logic [DW-1:0]    rx_byte;

    always_comb begin
        idx_nx = (eng_q.idx == {IDX_W{1'b1}}) ? eng_q.idx : eng_q.idx + 1'b1;
        rx_byte = {eng_q.sh[DW-2:0], ev.sda};
        tx_byte = '0;
        if (int'(idx_nx) == RD_HDR - 1) begin
            tx_byte = DW'(NREG);
        end
        for (int k = 0; k < NREG; k++) begin
            if (int'(idx_nx) == RD_HDR + k) begin
                tx_byte = regs_flat[k*DW +: DW];
            end
        end
    end

    always_comb begin
        eng_d   = eng_q;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = eng_q.sh;
        if (ev.start) begin
            eng_d        = ENG_IDLE;
            eng_d.st     = ST_RX;
        end else if (ev.stop) begin
            eng_d        = ENG_IDLE;
        end else begin
            case (eng_q.st)
                ST_RX: begin
                    if (ev.scl_rise) begin
                        eng_d.sh     = rx_byte;
                        eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                        if (eng_q.bitcnt == BC_W'(DW - 1)) begin
                            eng_d.st = ST_ACKWAIT;
                            if (eng_q.idx == '0) begin
                                eng_d.ack = (rx_byte[DW-1:1] == ADDR7);
                                eng_d.rd  = rx_byte[0];
                            end else begin
                                eng_d.ack = 1'b1;
                            end
                        end
                    end
                end
                ST_ACKWAIT: begin
                    if (ev.scl_fall) begin
                        if (eng_q.ack) begin
                            eng_d.pull = 1'b1;
                            eng_d.st   = ST_ACK;
                            if (!eng_q.rd && int'(eng_q.idx) >= WR_HDR
                                && int'(eng_q.idx) < WR_HDR + NREG) begin
                                wr_en  = 1'b1;
                                wr_idx = RIDX_W'(int'(eng_q.idx) - WR_HDR);
                            end
                        end else begin
                            eng_d = ENG_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        eng_d.idx    = idx_nx;
                        eng_d.bitcnt = '0;
                        if (eng_q.rd) begin
                            eng_d.st   = ST_TX;
                            eng_d.sh   = tx_byte;
                            eng_d.pull = ~tx_byte[DW-1];
                        end else begin
                            eng_d.st   = ST_RX;
                            eng_d.pull = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                    end
                    if (ev.scl_fall) begin
                        if (eng_q.bitcnt == BC_W'(DW)) begin
                            eng_d.pull = 1'b0;
                            eng_d.mack = 1'b0;
                            eng_d.st   = ST_MACK;
                        end else begin
                            eng_d.sh   = {eng_q.sh[DW-2:0], 1'b0};
                            eng_d.pull = ~eng_q.sh[DW-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        eng_d.mack = ~ev.sda;
                    end
                    if (ev.scl_fall) begin
                        if (eng_q.mack) begin
                            eng_d.idx    = idx_nx;
                            eng_d.bitcnt = '0;
                            eng_d.st     = ST_TX;
                            eng_d.sh     = tx_byte;
                            eng_d.pull   = ~tx_byte[DW-1];
                        end else begin
                            eng_d = ENG_IDLE;
                        end
                    end
                end
                default: begin
                    eng_d = eng_q;
                end
            endcase
        end
        if (pwr_down) begin
            eng_d = ENG_IDLE;
            wr_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= ENG_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_pull = eng_q.pull;

    AST_SDA_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.scl && $past(ev.scl) && !pwr_down && !$past(pwr_down)) |-> $stable(sda_pull)); // R2
    AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !sda_pull); // R8
    AST_NAK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eng_q.st == ST_MACK) && eng_q.st == ST_IDLE) |-> !sda_pull); // R7
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG)); // R5
    AST_RX_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_RX || eng_q.st == ST_ACKWAIT) |-> !sda_pull); // R9

endmodule

// File: rtl/ctlbus_slave.sv
module ctlbus_slave
    import ctlbus_pkg::*;
#(
    parameter int                 DW          = 8,
    parameter int                 NREG        = 6,
    parameter logic [6:0]         ADDR7       = 7'h69,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 IDX_W       = 4,
    parameter logic [NREG*DW-1:0] RESET_VAL   = 48'h0000_7EE0_3FF6,
    localparam int                RIDX_W      = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_down,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_pull,
    output logic [NREG*DW-1:0]   regs_flat
);

    bus_ev_t            ev;
    logic               wr_en;
    logic [RIDX_W-1:0]  wr_idx;
    logic [DW-1:0]      wr_data;

    ctlbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    ctlbus_engine #(.DW(DW), .NREG(NREG), .ADDR7(ADDR7), .IDX_W(IDX_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .ev        (ev),
        .regs_flat (regs_flat),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull)
    );

    ctlbus_regfile #(.DW(DW), .NREG(NREG), .RESET_VAL(RESET_VAL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> $stable(regs_flat)); // R8

endmodule

// File: tb/tb_ctlbus_slave.sv
module tb_ctlbus_slave;

    localparam int Q  = 25;
    localparam int WD = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic [47:0] regs_flat;
    wire         sda_line = sda_m & ~sda_pull;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    ctlbus_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .regs_flat (regs_flat)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [3:0]  ndata;
        logic [63:0] data;
        logic        exp_ack;
        logic [47:0] exp_regs;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'hD2, 4'd6, 64'h0000_6655_4433_2211, 1'b1, 48'h6655_4433_2211},
        '{8'hD2, 4'd2, 64'h0000_0000_0000_5AA5, 1'b1, 48'h6655_4433_5AA5},
        '{8'hA4, 4'd3, 64'h0000_0000_0003_0201, 1'b0, 48'h6655_4433_5AA5},
        '{8'hD0, 4'd6, 64'h0000_EEEE_EEEE_EEEE, 1'b0, 48'h6655_4433_5AA5},
        '{8'hD2, 4'd7, 64'h00C7_C6C5_C4C3_C2C1, 1'b1, 48'hC6C5_C4C3_C2C1},
        '{8'hD2, 4'd0, 64'h0000_0000_0000_0000, 1'b1, 48'hC6C5_C4C3_C2C1}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        qwait();
    endtask

    task automatic bus_bit(input logic v, output logic seen);
        sda_m = v;    qwait();
        scl_m = 1'b1; qwait();
        seen = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic [7:0] echo, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(b[i], s);
            echo[i] = s;
        end
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(~give_ack, s);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  e;
        logic [7:0]  rb;
        logic        a;
        logic        s;
        int          bad;
        logic [47:0] cur;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset values and released line
        chk(regs_flat == 48'h0000_7EE0_3FF6, "R1 defaults", 64'(regs_flat), 64'h0000_7EE0_3FF6);
        chk(sda_pull == 1'b0, "R1 pull off", 64'(sda_pull), 64'h0);

        // table walk: R3 address match, R4 sequential fill, R5 overflow discard
        for (int v = 0; v < 6; v++) begin
            bad = 0;
            bus_start();
            wr_byte(VECS[v].addr, e, a);
            chk(a == VECS[v].exp_ack, "R3 address ack", 64'(a), 64'(VECS[v].exp_ack));
            wr_byte(8'h5C, e, a);
            if (a != VECS[v].exp_ack) bad++;
            wr_byte(8'h09, e, a);
            if (a != VECS[v].exp_ack) bad++;
            for (int j = 0; j < int'(VECS[v].ndata); j++) begin
                wr_byte(VECS[v].data[8*j +: 8], e, a);
                if (a != VECS[v].exp_ack) bad++;
            end
            bus_stop();
            chk(bad == 0, "R5 data byte acks", 64'(bad), 64'h0);
            chk(regs_flat == VECS[v].exp_regs, "R4 register contents",
                64'(regs_flat), 64'(VECS[v].exp_regs));
        end
        cur = VECS[5].exp_regs;

        // R6 read-back, R7 release after NAK
        bus_start();
        wr_byte(8'hD3, e, a);
        chk(a == 1'b1, "R3 read address ack", 64'(a), 64'h1);
        rd_byte(1'b1, rb);
        chk(rb == 8'h06, "R6 count byte", 64'(rb), 64'h06);
        for (int k = 0; k < 6; k++) begin
            rd_byte(k != 5, rb);
            chk(rb == cur[8*k +: 8], "R6 register byte", 64'(rb), 64'(cur[8*k +: 8]));
        end
        rd_byte(1'b0, rb);
        chk(rb == 8'hFF, "R7 released after NAK", 64'(rb), 64'hFF);
        bus_stop();

        // R2 stop in the middle of a data byte
        bus_start();
        wr_byte(8'hD2, e, a);
        wr_byte(8'h00, e, a);
        wr_byte(8'h00, e, a);
        bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b0, s);
        bus_stop();
        chk(regs_flat == cur, "R2 stop aborts byte", 64'(regs_flat), 64'(cur));

        // R2 repeated start in the middle of a byte, then a new read
        bus_start();
        wr_byte(8'hD2, e, a);
        wr_byte(8'h00, e, a);
        wr_byte(8'h00, e, a);
        wr_byte(8'h77, e, a);
        bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b0, s);
        bus_start();
        wr_byte(8'hD3, e, a);
        chk(a == 1'b1, "R2 repeated start address ack", 64'(a), 64'h1);
        rd_byte(1'b1, rb);
        chk(rb == 8'h06, "R2 count after repeated start", 64'(rb), 64'h06);
        rd_byte(1'b1, rb);
        chk(rb == 8'h77, "R4 reg0 written", 64'(rb), 64'h77);
        rd_byte(1'b0, rb);
        chk(rb == cur[15:8], "R2 reg1 untouched", 64'(rb), 64'(cur[15:8]));
        bus_stop();
        cur[7:0] = 8'h77;
        chk(regs_flat == cur, "R2 register image", 64'(regs_flat), 64'(cur));

        // R8 power-down ignores traffic and keeps registers
        pwr_down = 1'b1;
        qwait();
        bad = 0;
        bus_start();
        wr_byte(8'hD2, e, a);
        chk(a == 1'b0, "R8 no ack in power-down", 64'(a), 64'h0);
        wr_byte(8'h00, e, a);
        if (a) bad++;
        wr_byte(8'h00, e, a);
        if (a) bad++;
        wr_byte(8'h99, e, a);
        if (a) bad++;
        bus_stop();
        chk(bad == 0, "R8 no data ack in power-down", 64'(bad), 64'h0);
        chk(regs_flat == cur, "R8 registers retained", 64'(regs_flat), 64'(cur));
        pwr_down = 1'b0;
        qwait();
        bus_start();
        wr_byte(8'hD3, e, a);
        chk(a == 1'b1, "R8 answers after power-down", 64'(a), 64'h1);
        rd_byte(1'b1, rb);
        rd_byte(1'b0, rb);
        chk(rb == 8'h77, "R8 reg0 after power-down", 64'(rb), 64'h77);
        bus_stop();

        // R9 no pull while master shifts in
        bad = 0;
        bus_start();
        wr_byte(8'hD2, e, a);
        if (e != 8'hD2) bad++;
        wr_byte(8'hFF, e, a);
        if (e != 8'hFF || a != 1'b1) bad++;
        wr_byte(8'hB7, e, a);
        if (e != 8'hB7 || a != 1'b1) bad++;
        wr_byte(8'h3C, e, a);
        if (e != 8'h3C || a != 1'b1) bad++;
        bus_stop();
        chk(bad == 0, "R9 line free during shift-in", 64'(bad), 64'h0);
        cur[7:0] = 8'h3C;
        chk(regs_flat == cur, "R9 write result", 64'(regs_flat), 64'(cur));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule